// File: doc/BRIEF.md
# Interrupt Message Event Ring Controller

This block accepts inbound message-signalled interrupt writes, each an address offset and a data word. The offset selects one of several queue groups, and the block stores the word in that group's circular ring in system memory. Hardware owns each ring's tail and software owns its head. When an insertion is accepted, the word goes out on a memory write port. Only after that write completes does the tail step forward. Each group has its own level interrupt, which stays high while the ring holds unread entries and the group's enables allow it.

Software reaches the per-group control, head, tail and flag registers, and a shared legacy gate register, through a simple register port. After consuming entries it writes the new head. A write that targets a disabled ring, or a ring with one free slot left, is absorbed without touching memory and sets a sticky flag.

Both data paths use valid/ready handshakes. `in_ready` is high only while no memory write is pending, so an upstream source stalls while the memory side holds `mem_wr_ready` low. The memory write holds its address and data stable until it is taken. Inbound writes are taken one at a time in arrival order.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset every head, tail, control, flag and legacy gate register reads zero, every `irq_o` bit is low and `in_ready` is high.
- R2: The group index is the inbound offset shifted right by 2 when `multi_region` is 0, and shifted right by 12 when it is 1. An index of NUM_GRP or above is accepted and has no effect on any register, memory write or interrupt.
- R3: An accepted insertion for group n issues one memory write with the data word unchanged. Its address is `eq_base` + n*256 + tail*4 in single-region mode, and `eq_base` + n*4096 + tail*4 in multi-region mode. Address and data hold stable while `mem_wr_ready` is low.
- R4: A group's tail grows by one only on the clock edge that completes its memory write. While that write is pending, `in_ready` is low.
- R5: A write to a group whose queue-enable bit (control bit 0) is clear causes no memory write, leaves the tail unchanged and sets flag bit 0 (drop), which stays set until reset.
- R6: A write to a group holding 63 entries ((tail-head) mod 64 = 63) causes no memory write, leaves the tail unchanged and sets flag bit 1 (overflow), which is sticky.
- R7: `irq_o[n]` is a registered level. In each cycle it equals the value, one cycle earlier, of control bits 0, 1 and 11 of group n ANDed with legacy gate bit n and with (head != tail).
- R8: Only the register port changes a head. Writing a head equal to the tail drops the interrupt one cycle later. Writes to a tail address are ignored.
- R9: The legacy gate register at address 4*NUM_GRP has bit n gating `irq_o[n]`.
- R10: The register address for group n is 4n + k, with k=0 control (bits 0, 1 and 11 are kept and others read 0), k=1 head, k=2 tail and k=3 flags.
- R11: Pointers wrap modulo 64, so a tail of 63 becomes 0 after one insertion and the slot-63 write lands at offset 252 within the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_region | input | 1 | 1 selects 4 KiB group stride for decode and ring placement |
| eq_base | input | MEM_AW | Base address of ring memory |
| in_valid | input | 1 | Inbound write valid |
| in_ready | output | 1 | Inbound write ready |
| in_addr | input | ADDR_W | Inbound write address offset |
| in_data | input | DATA_W | Inbound write data word |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | MEM_AW | Memory write byte address |
| mem_wr_data | output | DATA_W | Memory write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| irq_o | output | NUM_GRP | Per-group level interrupt |

## Verification
Insertions are sent in single-region and multi-region mode to several groups. This separates the two offset shifts and the two ring strides in the emitted memory address. The memory side stalls in a repeating pattern, which shows the tail moving only on a completed write and the inbound side held off meanwhile. Writes to a disabled group, to an out-of-range index, and to a ring filled to 63 entries tell a proper drop apart from a silent insertion or a pointer collision. One ring is then filled past slot 63 to exercise the wrap. Head writes, control-bit clears and legacy gate changes each toggle the interrupt alone, so every term of the interrupt product is observed by itself.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
  localparam int CTRL_QEN = 0;
  localparam int CTRL_EVT = 1;
  localparam int CTRL_IEN = 11;
  localparam int CTRL_W   = 12;
  localparam logic [CTRL_W-1:0] CTRL_MASK =
    CTRL_W'((1 << CTRL_QEN) | (1 << CTRL_EVT) | (1 << CTRL_IEN));

  localparam int FLD_CTRL = 0;
  localparam int FLD_HEAD = 1;
  localparam int FLD_TAIL = 2;
  localparam int FLD_FLAG = 3;

  localparam int SINGLE_SHIFT = 2;
  localparam int MULTI_SHIFT  = 12;
  localparam int SLOT_SHIFT   = 2;

  typedef enum logic {ST_IDLE, ST_WRITE} evq_state_e;
endpackage

// File: rtl/msi_evq_decode.sv
module msi_evq_decode
  import msi_evq_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int ADDR_W  = 16,
  parameter int MEM_AW  = 32,
  parameter int PTR_W   = 6,
  parameter int GRP_W   = 3
) (
  input  logic              multi_region,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [GRP_W-1:0]  grp_idx,
  output logic              grp_hit,
  input  logic [MEM_AW-1:0] eq_base,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [PTR_W-1:0]  wr_tail,
  output logic [MEM_AW-1:0] slot_addr
);
  localparam int RING_SHIFT = PTR_W + SLOT_SHIFT;

  logic [ADDR_W-1:0] sel;
  logic [MEM_AW-1:0] ring_off;

  always_comb begin
    sel     = multi_region ? (in_addr >> MULTI_SHIFT) : (in_addr >> SINGLE_SHIFT);
    grp_hit = (sel < ADDR_W'(NUM_GRP));
    grp_idx = sel[GRP_W-1:0];
  end

  always_comb begin
    ring_off  = multi_region ? (MEM_AW'(wr_grp) << MULTI_SHIFT)
                             : (MEM_AW'(wr_grp) << RING_SHIFT);
    slot_addr = eq_base + ring_off + (MEM_AW'(wr_tail) << SLOT_SHIFT);
  end
endmodule

// File: rtl/msi_evq_ring.sv
module msi_evq_ring
  import msi_evq_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic              head_we,
  input  logic [PTR_W-1:0]  head_wd,
  input  logic              push,
  input  logic              drop_dis,
  input  logic              drop_full,
  input  logic              gate_en,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [PTR_W-1:0]  head_q,
  output logic [PTR_W-1:0]  tail_q,
  output logic              full,
  output logic              drop_flag,
  output logic              ovf_flag,
  output logic              irq
);
  logic irq_next;

  assign full = (PTR_W'(tail_q + 1'b1) == head_q);
  assign irq_next = ctrl_q[CTRL_QEN] & ctrl_q[CTRL_EVT] & ctrl_q[CTRL_IEN]
                  & gate_en & (head_q != tail_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      drop_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (ctrl_we)   ctrl_q    <= ctrl_wd & CTRL_MASK;
      if (head_we)   head_q    <= head_wd;
      if (push)      tail_q    <= tail_q + 1'b1;
      if (drop_dis)  drop_flag <= 1'b1;
      if (drop_full) ovf_flag  <= 1'b1;
      irq <= irq_next;
    end
  end
endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl
  import msi_evq_pkg::*;
#(
  parameter int NUM_GRP    = 6,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MEM_AW     = 32,
  parameter int PTR_W      = 6,
  parameter bit HAS_LEGACY = 1'b1,
  localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int RA_W      = $clog2(NUM_GRP * 4 + 1),
  localparam int REG_W     = (NUM_GRP > CTRL_W) ? NUM_GRP : CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               multi_region,
  input  logic [MEM_AW-1:0]  eq_base,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [DATA_W-1:0]  in_data,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [MEM_AW-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [NUM_GRP-1:0] irq_o
);
  evq_state_e state;
  logic [GRP_W-1:0]  grp_q;
  logic [DATA_W-1:0] data_q;

  logic [NUM_GRP-1:0][CTRL_W-1:0] ctrl_v;
  logic [NUM_GRP-1:0][PTR_W-1:0]  head_v;
  logic [NUM_GRP-1:0][PTR_W-1:0]  tail_v;
  logic [NUM_GRP-1:0] full_v, drop_v, ovf_v;
  logic [NUM_GRP-1:0] sel_v, push_v, dis_v, fdrop_v, ins_v;
  logic [NUM_GRP-1:0] leg_q;

  logic [GRP_W-1:0]  grp_idx;
  logic              grp_hit;
  logic [PTR_W-1:0]  tail_sel;
  logic              accept, start_wr, done_wr;

  assign in_ready     = (state == ST_IDLE);
  assign accept       = in_valid & in_ready;
  assign mem_wr_valid = (state == ST_WRITE);
  assign mem_wr_data  = data_q;
  assign done_wr      = mem_wr_valid & mem_wr_ready;
  assign start_wr     = |ins_v;

  msi_evq_decode #(
    .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW),
    .PTR_W(PTR_W), .GRP_W(GRP_W)
  ) u_dec (
    .multi_region(multi_region),
    .in_addr     (in_addr),
    .grp_idx     (grp_idx),
    .grp_hit     (grp_hit),
    .eq_base     (eq_base),
    .wr_grp      (grp_q),
    .wr_tail     (tail_sel),
    .slot_addr   (mem_wr_addr)
  );

  always_comb begin
    tail_sel = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_q == GRP_W'(g)) tail_sel = tail_v[g];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ring
    logic ctrl_we, head_we;
    assign sel_v[g]   = accept & grp_hit & (grp_idx == GRP_W'(g));
    assign dis_v[g]   = sel_v[g] & ~ctrl_v[g][CTRL_QEN];
    assign fdrop_v[g] = sel_v[g] &  ctrl_v[g][CTRL_QEN] & full_v[g];
    assign ins_v[g]   = sel_v[g] &  ctrl_v[g][CTRL_QEN] & ~full_v[g];
    assign push_v[g]  = done_wr & (grp_q == GRP_W'(g));
    assign ctrl_we    = reg_wr & (reg_addr == RA_W'(4 * g + FLD_CTRL));
    assign head_we    = reg_wr & (reg_addr == RA_W'(4 * g + FLD_HEAD));

    msi_evq_ring #(.PTR_W(PTR_W)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we),
      .ctrl_wd  (reg_wdata[CTRL_W-1:0]),
      .head_we  (head_we),
      .head_wd  (reg_wdata[PTR_W-1:0]),
      .push     (push_v[g]),
      .drop_dis (dis_v[g]),
      .drop_full(fdrop_v[g]),
      .gate_en  (leg_q[g]),
      .ctrl_q   (ctrl_v[g]),
      .head_q   (head_v[g]),
      .tail_q   (tail_v[g]),
      .full     (full_v[g]),
      .drop_flag(drop_v[g]),
      .ovf_flag (ovf_v[g]),
      .irq      (irq_o[g])
    );
  end

  if (HAS_LEGACY) begin : g_leg
    always_ff @(posedge clk) begin
      if (!rst_n) leg_q <= '0;
      else if (reg_wr && reg_addr == RA_W'(4 * NUM_GRP)) leg_q <= reg_wdata[NUM_GRP-1:0];
    end
  end else begin : g_noleg
    assign leg_q = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      grp_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_wr) begin
          state  <= ST_WRITE;
          grp_q  <= grp_idx;
          data_q <= in_data;
        end
        ST_WRITE: if (mem_wr_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == RA_W'(4 * g + FLD_CTRL)) reg_rdata = REG_W'(ctrl_v[g]);
      if (reg_addr == RA_W'(4 * g + FLD_HEAD)) reg_rdata = REG_W'(head_v[g]);
      if (reg_addr == RA_W'(4 * g + FLD_TAIL)) reg_rdata = REG_W'(tail_v[g]);
      if (reg_addr == RA_W'(4 * g + FLD_FLAG)) reg_rdata = REG_W'({ovf_v[g], drop_v[g]});
    end
    if (HAS_LEGACY && reg_addr == RA_W'(4 * NUM_GRP)) reg_rdata = REG_W'(leg_q);
  end
endmodule

// File: rtl/msi_evq_chk.sv
module msi_evq_chk
  import msi_evq_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int DATA_W  = 32,
  parameter int MEM_AW  = 32,
  parameter int PTR_W   = 6,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_ready,
  input logic                           mem_wr_valid,
  input logic                           mem_wr_ready,
  input logic [MEM_AW-1:0]              mem_wr_addr,
  input logic [DATA_W-1:0]              mem_wr_data,
  input logic                           reg_wr,
  input logic [NUM_GRP-1:0]             irq_o,
  input logic [NUM_GRP-1:0][CTRL_W-1:0] ctrl_v,
  input logic [NUM_GRP-1:0][PTR_W-1:0]  head_v,
  input logic [NUM_GRP-1:0][PTR_W-1:0]  tail_v,
  input logic [GRP_W-1:0]               grp_q
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R3

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !in_ready); // R4

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_valid && mem_wr_ready && grp_q == GRP_W'(g)) |=> $stable(tail_v[g])); // R4

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_ready && grp_q == GRP_W'(g))
        |=> (tail_v[g] == PTR_W'($past(tail_v[g]) + 1'b1))); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_ready && !reg_wr && grp_q == GRP_W'(g))
        |=> (tail_v[g] != head_v[g])); // R6

    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (head_v[g] == tail_v[g]) |=> !irq_o[g]); // R7

    AST_IRQ_QOFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_v[g][CTRL_QEN] |=> !irq_o[g]); // R7
  end
endmodule

bind msi_evq_ctrl msi_evq_chk #(
  .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .PTR_W(PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .reg_wr      (reg_wr),
  .irq_o       (irq_o),
  .ctrl_v      (ctrl_v),
  .head_v      (head_v),
  .tail_v      (tail_v),
  .grp_q       (grp_q)
);

// File: tb/msi_evq_ctrl_tb_top.sv
module msi_evq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 6;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        multi_region = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic [NG-1:0] irq_o;

  msi_evq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .multi_region(multi_region), .eq_base(BASE),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_head[NG], m_tail[NG], m_ctrl[NG], m_drop[NG], m_ovf[NG];
  int m_leg;
  bit m_pend;
  int m_pg;
  logic [31:0] m_pd;
  logic [NG-1:0] e_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        m_head[g] = 0; m_tail[g] = 0; m_ctrl[g] = 0; m_drop[g] = 0; m_ovf[g] = 0;
      end
      m_leg = 0; m_pend = 0; m_pg = 0; m_pd = '0; e_irq = '0;
    end else begin
      for (int g = 0; g < NG; g++)
        e_irq[g] = (m_ctrl[g] & 'h803) == 'h803 && ((m_leg >> g) & 1) == 1
                   && m_head[g] != m_tail[g];
      if (in_valid && in_ready) begin
        int sel;
        sel = multi_region ? int'(in_addr >> 12) : int'(in_addr >> 2);
        if (sel < NG) begin
          if ((m_ctrl[sel] & 1) == 0) m_drop[sel] = 1;
          else if (((m_tail[sel] - m_head[sel]) & 63) == 63) m_ovf[sel] = 1;
          else begin m_pend = 1; m_pg = sel; m_pd = in_data; end
        end
      end else if (mem_wr_valid && mem_wr_ready) begin
        logic [31:0] ea;
        ea = BASE + 32'(m_pg * (multi_region ? 4096 : 256)) + 32'(m_tail[m_pg] * 4);
        chk(m_pend && mem_wr_addr == ea, "R3 memory address", mem_wr_addr, ea);
        chk(mem_wr_data == m_pd, "R3 memory data", mem_wr_data, m_pd);
        m_tail[m_pg] = (m_tail[m_pg] + 1) % 64;
        m_pend = 0;
      end
      if (reg_wr) begin
        int a;
        a = int'(reg_addr);
        if (a == 4 * NG) m_leg = int'(reg_wdata) & 63;
        else if (a < 4 * NG) begin
          if (a % 4 == 0) m_ctrl[a / 4] = int'(reg_wdata) & 'h803;
          if (a % 4 == 1) m_head[a / 4] = int'(reg_wdata) & 63;
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_o == e_irq, "R7 irq level", irq_o, e_irq);
      chk(in_ready == !m_pend, "R4 in_ready", in_ready, !m_pend);
      chk(mem_wr_valid == m_pend, "R4 mem_wr_valid", mem_wr_valid, m_pend);
    end
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    mem_wr_ready = (cyc % 4) != 0;
  end

  function automatic int mval(input int a);
    if (a == 4 * NG) return m_leg;
    if (a >= 4 * NG) return 0;
    case (a % 4)
      0: return m_ctrl[a / 4];
      1: return m_head[a / 4];
      2: return m_tail[a / 4];
      default: return m_drop[a / 4] | (m_ovf[a / 4] << 1);
    endcase
  endfunction

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    reg_addr = 5'(a);
    #1;
    chk(int'(reg_rdata) == mval(a), tag, reg_rdata, mval(a));
  endtask

  task automatic rdx(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = 5'(a);
    #1;
    chk(int'(reg_rdata) == exp, tag, reg_rdata, exp);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 12'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input int a, input logic [31:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = 16'(a); in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (mem_wr_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    @(negedge clk);
    chk(irq_o == '0, "R1 irq after reset", irq_o, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    for (int a = 0; a <= 4 * NG; a++) rdx(a, 0, "R1 register reset value");

    // R10: control masking, R9 legacy register
    wr(4 * NG, 63);
    rdx(4 * NG, 63, "R9 legacy readback");
    for (int g = 0; g < NG; g++) wr(4 * g, 'hFFF);
    rdx(8, 'h803, "R10 control keeps bits 0,1,11");

    // R2/R3: single-region insertion into group 2
    send(2 * 4, 32'h1234_5641);
    settle();
    rdx(4 * 2 + 2, 1, "R4 tail after one insertion");
    chk(irq_o[2] == 1'b1, "R7 irq raised", irq_o[2], 1);
    // R8: head = tail drops the interrupt
    wr(4 * 2 + 1, 1);
    @(negedge clk);
    chk(irq_o[2] == 1'b0, "R8 irq cleared after head write", irq_o[2], 0);
    // R8: tail is read-only
    wr(4 * 2 + 2, 9);
    rdx(4 * 2 + 2, 1, "R8 tail write ignored");

    // R2/R3: multi-region insertion into group 3
    multi_region = 1'b1;
    send(3 << 12, 32'hCAFE_0003);
    send((5 << 12) + 12, 32'hBEEF_00A5);
    settle();
    rd(4 * 3 + 2, "R2 multi-region tail group 3");
    rd(4 * 5 + 2, "R2 multi-region tail group 5");
    multi_region = 1'b0;

    // R2: out-of-range index has no effect
    send(NG * 4, 32'hDEAD_0000);
    send(7 * 4, 32'hDEAD_0001);
    settle();
    for (int g = 0; g < NG; g++) rd(4 * g + 2, "R2 out of range leaves tails");

    // R5: disabled group
    wr(4 * 1, 0);
    send(1 * 4, 32'h0000_0111);
    settle();
    rdx(4 * 1 + 3, 1, "R5 drop flag");
    rdx(4 * 1 + 2, 0, "R5 tail unchanged");
    wr(4 * 1, 'h803);
    rdx(4 * 1 + 3, 1, "R5 drop flag sticky");

    // R6: fill group 0 to 63 entries, then overflow
    for (int i = 0; i < 63; i++) send(0, 32'(i) << 5);
    send(0, 32'hFFFF_FFE0);
    settle();
    rdx(2, 63, "R6 tail at 63 entries");
    rdx(3, 2, "R6 overflow flag");
    // R11: wrap
    wr(1, 63);
    @(negedge clk);
    chk(irq_o[0] == 1'b0, "R8 irq off at head==tail", irq_o[0], 0);
    send(0, 32'h0000_07E1);
    send(0, 32'h0000_0002);
    settle();
    rdx(2, 1, "R11 tail wrapped to 1");

    // R9: legacy gate on group 0
    chk(irq_o[0] == 1'b1, "R7 irq after wrap", irq_o[0], 1);
    wr(4 * NG, 62);
    @(negedge clk);
    chk(irq_o[0] == 1'b0, "R9 legacy bit gates irq", irq_o[0], 0);
    wr(4 * NG, 63);
    // R7: clearing event bit
    wr(0, 'h801);
    @(negedge clk);
    chk(irq_o[0] == 1'b0, "R7 event bit clear", irq_o[0], 0);
    wr(0, 'h803);
    @(negedge clk);
    chk(irq_o[0] == 1'b1, "R7 irq restored", irq_o[0], 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule